// File: doc/BRIEF.md
# Programmable Down-Counting Interval Timer

This block is a 32-bit down-counter with a small register file on a 16-bit read/write bus. Software sets a period, picks single-shot or auto-reload operation, and starts or halts the count with write-one action bits. Each time the count runs out, the block raises a sticky timeout flag. That flag drives the interrupt line when the interrupt enable is set, and it stays set until software writes the status register.

The live count cannot be read directly. A write to the low snapshot register freezes the whole count into a holding register, so both 16-bit halves can be read later and still agree with each other. A loaded period value P gives a timeout every P+1 clock cycles. With all ones loaded, the block works as a free-running 32-bit cycle counter.

Top module: `interval_timer`

## Requirements
- R1: After a synchronous active-low reset, the block is in this state: counter stopped, count and period all ones, interrupt enable and auto-reload clear, timeout flag clear, snapshot zero, `irq` low.
- R2: Registers decode from `bus_addr[4:2]` when `bus_addr[1:0]` is zero. The map is: 0 status, 1 control, 2 period low, 3 period high, 4 snapshot low, 5 snapshot high. Every other index reads as zero. Status bit 0 is the timeout flag and status bit 1 is the running state. Control bit 0 (interrupt enable) and control bit 1 (auto-reload) are stored and read back. Control bits 2 and 3 always read as zero.
- R3: While running, the count falls by one on each clock. With period P loaded, a timeout occurs P+1 cycles apart.
- R4: With auto-reload clear, the counter reloads the period at timeout and then stops.
- R5: With auto-reload set, the counter reloads the period at timeout and keeps running.
- R6: Writing control with bit 2 set starts the counter. Writing control with bit 3 set halts it and holds the count. When both bits are 1 in one write, halt wins.
- R7: A write to either period half stops the counter and loads it with the new 32-bit period.
- R8: Any write to snapshot low captures the count as it was before that clock edge. Both snapshot halves read back the captured value. A write to snapshot high has no effect.
- R9: Any write to status clears the timeout flag. A timeout on the same cycle as the write takes precedence, so the flag stays set.
- R10: `irq` is high exactly while the timeout flag and the interrupt enable are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 5 | Byte address of the register |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Timeout interrupt |

## Verification
The assertions assume that every write is a single-cycle `bus_wr` pulse, with address and data stable across the edge that takes it. They also assume that reset is held for at least one clock edge before the first access. The stimulus changes bus signals only on falling edges and performs exactly one access, or one idle span, per rising edge. This puts every expected count at a known cycle offset from the start write. Addresses are always word aligned, except for one deliberate read of an unused index.

// File: rtl/itmr_pkg.sv
// Package: shared register indices and bit positions for the interval timer.
// Assumes a word-aligned byte address whose bits [4:2] select the register.
package itmr_pkg;

    // Register index, taken from the byte address divided by four.
    typedef enum logic [2:0] {
        IDX_STATUS  = 3'd0,
        IDX_CTRL    = 3'd1,
        IDX_PER_LO  = 3'd2,
        IDX_PER_HI  = 3'd3,
        IDX_SNAP_LO = 3'd4,
        IDX_SNAP_HI = 3'd5
    } reg_idx_e;

    // Control bit positions.
    localparam int CTL_IEN  = 0;
    localparam int CTL_AUTO = 1;
    localparam int CTL_GO   = 2;
    localparam int CTL_HALT = 3;

    // Status bit positions.
    localparam int ST_FLAG  = 0;
    localparam int ST_RUN   = 1;

endpackage

// File: rtl/itmr_regfile.sv
// Register file: decodes bus writes into stored control bits, the split
// period and action strobes, and muxes read data.
// Assumes bus_wr is a one-cycle pulse and the address is word aligned.
module itmr_regfile #(
    parameter int HALF_W = 16,
    parameter int ADDR_W = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   addr,
    input  logic                wr_en,
    input  logic [HALF_W-1:0]   wdata,
    input  logic                run,
    input  logic                flag,
    input  logic [2*HALF_W-1:0] snap,
    output logic                ien,
    output logic                auto_rl,
    output logic                start_pulse,
    output logic                stop_pulse,
    output logic                period_wr,
    output logic [2*HALF_W-1:0] period_d,
    output logic [2*HALF_W-1:0] period_q,
    output logic                snap_take,
    output logic                clr_flag,
    output logic [HALF_W-1:0]   rdata
);
    import itmr_pkg::*;

    localparam int CNT_W = 2 * HALF_W;
    localparam int IDX_W = ADDR_W - 2;
    localparam int NHALF = CNT_W / HALF_W;

    logic             aligned;
    logic [IDX_W-1:0] idx;
    logic             wr_ctrl;
    logic [NHALF-1:0] per_sel;

    // Split address into alignment check and register index.
    always_comb begin
        aligned = (addr[1:0] == 2'b00);
        idx     = addr[ADDR_W-1:2];
    end

    // Decode write strobes; halt has priority over go.
    always_comb begin
        wr_ctrl     = wr_en && aligned && (idx == IDX_W'(IDX_CTRL));
        stop_pulse  = wr_ctrl && wdata[CTL_HALT];
        start_pulse = wr_ctrl && wdata[CTL_GO] && !wdata[CTL_HALT];
        snap_take   = wr_en && aligned && (idx == IDX_W'(IDX_SNAP_LO));
        clr_flag    = wr_en && aligned && (idx == IDX_W'(IDX_STATUS));
        per_sel[0]  = wr_en && aligned && (idx == IDX_W'(IDX_PER_LO));
        per_sel[1]  = wr_en && aligned && (idx == IDX_W'(IDX_PER_HI));
        period_wr   = |per_sel;
    end

    // Next period value: each half takes write data when selected.
    for (genvar g = 0; g < NHALF; g++) begin : g_per_half
        assign period_d[g*HALF_W +: HALF_W] =
            per_sel[g] ? wdata : period_q[g*HALF_W +: HALF_W];
    end

    // Period register, all ones after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            period_q <= '1;
        end else if (period_wr) begin
            period_q <= period_d;
        end
    end

    // Stored control bits: interrupt enable and auto-reload.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ien     <= 1'b0;
            auto_rl <= 1'b0;
        end else if (wr_ctrl) begin
            ien     <= wdata[CTL_IEN];
            auto_rl <= wdata[CTL_AUTO];
        end
    end

    // Read data multiplexer; unused indices and unaligned reads give zero.
    always_comb begin
        rdata = '0;
        if (aligned) begin
            case (idx)
                IDX_W'(IDX_STATUS): begin
                    rdata[ST_FLAG] = flag;
                    rdata[ST_RUN]  = run;
                end
                IDX_W'(IDX_CTRL): begin
                    rdata[CTL_IEN]  = ien;
                    rdata[CTL_AUTO] = auto_rl;
                end
                IDX_W'(IDX_PER_LO):  rdata = period_q[0 +: HALF_W];
                IDX_W'(IDX_PER_HI):  rdata = period_q[HALF_W +: HALF_W];
                IDX_W'(IDX_SNAP_LO): rdata = snap[0 +: HALF_W];
                IDX_W'(IDX_SNAP_HI): rdata = snap[HALF_W +: HALF_W];
                default:             rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/itmr_counter.sv
// Counter core: down-counts while running and reloads from the period at
// zero. A period write loads the count and stops the counter. Halt wins
// over go. Assumes the action strobes last one cycle.
module itmr_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_pulse,
    input  logic             stop_pulse,
    input  logic             auto_rl,
    input  logic             period_wr,
    input  logic [CNT_W-1:0] period_d,
    input  logic [CNT_W-1:0] period_q,
    output logic [CNT_W-1:0] cnt_q,
    output logic             run_q,
    output logic             tick
);

    // Timeout event: running, not halted this cycle, count at zero.
    always_comb begin
        tick = run_q && !stop_pulse && !period_wr && (cnt_q == '0);
    end

    // Count and run state update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '1;
            run_q <= 1'b0;
        end else if (period_wr) begin
            cnt_q <= period_d;
            run_q <= 1'b0;
        end else begin
            if (run_q && !stop_pulse) begin
                cnt_q <= tick ? period_q : cnt_q - 1'b1;
            end
            if (stop_pulse) begin
                run_q <= 1'b0;
            end else if (start_pulse) begin
                run_q <= 1'b1;
            end else if (tick && !auto_rl) begin
                run_q <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/itmr_snapshot.sv
// Snapshot holder: captures the full count in a single cycle so that both
// halves can be read later without tearing. Assumes take lasts one cycle.
module itmr_snapshot #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             take,
    input  logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] snap_q
);

    // Capture the pre-edge count on a take strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            snap_q <= '0;
        end else if (take) begin
            snap_q <= cnt;
        end
    end

endmodule

// File: rtl/itmr_irq.sv
// Timeout flag and interrupt: a sticky flag set by each timeout and cleared
// by a status write. A timeout on the same cycle keeps the flag set.
module itmr_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic clr,
    input  logic ien,
    output logic flag_q,
    output logic irq
);

    // Sticky flag, set priority over clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (tick) begin
            flag_q <= 1'b1;
        end else if (clr) begin
            flag_q <= 1'b0;
        end
    end

    // Interrupt line gated by the enable bit.
    always_comb begin
        irq = flag_q && ien;
    end

endmodule

// File: rtl/interval_timer.sv
// Top of the interval timer: the register file, the counter core, the
// snapshot holder and the interrupt logic. Assumes a single clock domain,
// synchronous active-low reset and one-cycle write strobes.
module interval_timer #(
    parameter int HALF_W = 16,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [HALF_W-1:0] bus_wdata,
    output logic [HALF_W-1:0] bus_rdata,
    output logic              irq
);

    localparam int CNT_W = 2 * HALF_W;

    logic             ien_q;
    logic             auto_q;
    logic             start_pulse;
    logic             stop_pulse;
    logic             period_wr;
    logic [CNT_W-1:0] period_d;
    logic [CNT_W-1:0] per_q;
    logic             snap_take;
    logic             clr_flag;
    logic [CNT_W-1:0] cnt_q;
    logic             run_q;
    logic             tick;
    logic [CNT_W-1:0] snap_q;
    logic             flag_q;

    itmr_regfile #(.HALF_W(HALF_W), .ADDR_W(ADDR_W)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .addr        (bus_addr),
        .wr_en       (bus_wr),
        .wdata       (bus_wdata),
        .run         (run_q),
        .flag        (flag_q),
        .snap        (snap_q),
        .ien         (ien_q),
        .auto_rl     (auto_q),
        .start_pulse (start_pulse),
        .stop_pulse  (stop_pulse),
        .period_wr   (period_wr),
        .period_d    (period_d),
        .period_q    (per_q),
        .snap_take   (snap_take),
        .clr_flag    (clr_flag),
        .rdata       (bus_rdata)
    );

    itmr_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_pulse (start_pulse),
        .stop_pulse  (stop_pulse),
        .auto_rl     (auto_q),
        .period_wr   (period_wr),
        .period_d    (period_d),
        .period_q    (per_q),
        .cnt_q       (cnt_q),
        .run_q       (run_q),
        .tick        (tick)
    );

    itmr_snapshot #(.CNT_W(CNT_W)) u_snap (
        .clk    (clk),
        .rst_n  (rst_n),
        .take   (snap_take),
        .cnt    (cnt_q),
        .snap_q (snap_q)
    );

    itmr_irq u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick),
        .clr    (clr_flag),
        .ien    (ien_q),
        .flag_q (flag_q),
        .irq    (irq)
    );

endmodule

// File: rtl/itmr_checker.sv
// Checker: temporal properties of the interval timer, bound to the top.
// Assumes one-cycle write strobes and a synchronous active-low reset.
module itmr_checker #(
    parameter int HALF_W = 16
) (
    input logic                clk,
    input logic                rst_n,
    input logic [2*HALF_W-1:0] cnt_q,
    input logic [2*HALF_W-1:0] per_q,
    input logic [2*HALF_W-1:0] snap_q,
    input logic                run_q,
    input logic                flag_q,
    input logic                ien_q,
    input logic                auto_q,
    input logic                start_pulse,
    input logic                stop_pulse,
    input logic                period_wr,
    input logic                snap_take,
    input logic                clr_flag,
    input logic                tick,
    input logic                irq
);

    localparam int CNT_W = 2 * HALF_W;

    p_reset_state_r1: assert property (@(posedge clk)
        $rose(rst_n) |-> (!run_q && !flag_q && !irq && cnt_q == {CNT_W{1'b1}}));

    p_count_down_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && !stop_pulse && !period_wr && cnt_q != '0)
        |=> (cnt_q == $past(cnt_q) - 1'b1));

    p_single_shot_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && !stop_pulse && !period_wr && cnt_q == '0 && !auto_q && !start_pulse)
        |=> !run_q);

    p_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && !stop_pulse && !period_wr && cnt_q == '0)
        |=> (cnt_q == $past(per_q) && flag_q));

    p_halt_r6: assert property (@(posedge clk) disable iff (!rst_n)
        stop_pulse |=> (!run_q && $stable(cnt_q)));

    p_period_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
        period_wr |=> (!run_q && cnt_q == per_q));

    p_snapshot_r8: assert property (@(posedge clk) disable iff (!rst_n)
        snap_take |=> (snap_q == $past(cnt_q)));

    p_flag_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_flag && !tick) |=> !flag_q);

    p_irq_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (flag_q && ien_q));

    p_irq_follow_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && ien_q) |-> irq);

endmodule

bind interval_timer itmr_checker #(.HALF_W(HALF_W)) u_itmr_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cnt_q       (cnt_q),
    .per_q       (per_q),
    .snap_q      (snap_q),
    .run_q       (run_q),
    .flag_q      (flag_q),
    .ien_q       (ien_q),
    .auto_q      (auto_q),
    .start_pulse (start_pulse),
    .stop_pulse  (stop_pulse),
    .period_wr   (period_wr),
    .snap_take   (snap_take),
    .clr_flag    (clr_flag),
    .tick        (tick),
    .irq         (irq)
);

// File: tb/test_interval_timer.sv
// Bench: a vector table walked by one loop, then directed tests for the
// interrupt gate, a clear that collides with a timeout, and reset mid-run.
module test_interval_timer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        irq;
    int          n_chk = 0;
    int          n_bad = 0;
    bit          done = 1'b0;

    always #2 clk = ~clk;

    interval_timer i_interval_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    // Vector: {req[3:0], op[1:0], addr[4:0], data[15:0], expected[15:0]}
    // op 0 = idle for data cycles, 1 = write, 2 = read and compare.
    localparam int NV = 66;
    localparam logic [42:0] VEC [NV] = '{
        {4'd1, 2'd2, 5'd0,  16'h0000, 16'h0000},  // R1 status
        {4'd1, 2'd2, 5'd4,  16'h0000, 16'h0000},  // R1 control
        {4'd1, 2'd2, 5'd8,  16'h0000, 16'hFFFF},  // R1 period low
        {4'd1, 2'd2, 5'd12, 16'h0000, 16'hFFFF},  // R1 period high
        {4'd1, 2'd2, 5'd16, 16'h0000, 16'h0000},  // R1 snapshot
        {4'd7, 2'd1, 5'd8,  16'h000A, 16'h0000},  // R7 period = 10
        {4'd7, 2'd1, 5'd12, 16'h0000, 16'h0000},
        {4'd7, 2'd2, 5'd0,  16'h0000, 16'h0000},  // R7 stopped
        {4'd2, 2'd2, 5'd8,  16'h0000, 16'h000A},  // R2 readback
        {4'd8, 2'd1, 5'd16, 16'h0000, 16'h0000},  // R8 capture stopped count
        {4'd8, 2'd2, 5'd20, 16'h0000, 16'h0000},
        {4'd7, 2'd2, 5'd16, 16'h0000, 16'h000A},  // R7 count loaded
        {4'd6, 2'd1, 5'd4,  16'h0004, 16'h0000},  // R6 go, single shot
        {4'd3, 2'd0, 5'd0,  16'd3,    16'h0000},
        {4'd3, 2'd1, 5'd16, 16'h0000, 16'h0000},
        {4'd3, 2'd2, 5'd16, 16'h0000, 16'h0007},  // R3 10 - 3
        {4'd2, 2'd2, 5'd0,  16'h0000, 16'h0002},  // R2 running bit
        {4'd6, 2'd1, 5'd4,  16'h0008, 16'h0000},  // R6 halt
        {4'd6, 2'd1, 5'd16, 16'h0000, 16'h0000},
        {4'd6, 2'd2, 5'd16, 16'h0000, 16'h0004},  // R6 count held
        {4'd6, 2'd2, 5'd0,  16'h0000, 16'h0000},
        {4'd6, 2'd1, 5'd4,  16'h0004, 16'h0000},  // R6 resume
        {4'd4, 2'd0, 5'd0,  16'd5,    16'h0000},
        {4'd4, 2'd2, 5'd0,  16'h0000, 16'h0001},  // R4 flag, stopped
        {4'd4, 2'd1, 5'd16, 16'h0000, 16'h0000},
        {4'd4, 2'd2, 5'd16, 16'h0000, 16'h000A},  // R4 reloaded
        {4'd2, 2'd2, 5'd4,  16'h0000, 16'h0000},  // R2 strobes read zero
        {4'd9, 2'd1, 5'd0,  16'h0000, 16'h0000},  // R9 clear
        {4'd9, 2'd2, 5'd0,  16'h0000, 16'h0000},
        {4'd7, 2'd1, 5'd8,  16'h0002, 16'h0000},  // period = 2
        {4'd7, 2'd1, 5'd12, 16'h0000, 16'h0000},
        {4'd5, 2'd1, 5'd4,  16'h0007, 16'h0000},  // R5 go, reload, ien
        {4'd3, 2'd0, 5'd0,  16'd3,    16'h0000},
        {4'd3, 2'd2, 5'd0,  16'h0000, 16'h0003},  // R3 timeout after P+1
        {4'd9, 2'd1, 5'd0,  16'h0000, 16'h0000},
        {4'd9, 2'd2, 5'd0,  16'h0000, 16'h0002},  // R9 cleared, still running
        {4'd5, 2'd2, 5'd0,  16'h0000, 16'h0003},  // R5 next timeout
        {4'd2, 2'd2, 5'd4,  16'h0000, 16'h0003},  // R2 control readback
        {4'd6, 2'd1, 5'd4,  16'h000F, 16'h0000},  // R6 go+halt
        {4'd6, 2'd2, 5'd0,  16'h0000, 16'h0001},  // R6 halt wins
        {4'd2, 2'd2, 5'd4,  16'h0000, 16'h0003},
        {4'd9, 2'd1, 5'd0,  16'h0000, 16'h0000},
        {4'd9, 2'd2, 5'd0,  16'h0000, 16'h0000},
        {4'd3, 2'd1, 5'd8,  16'hFFFF, 16'h0000},  // free-running period
        {4'd3, 2'd1, 5'd12, 16'hFFFF, 16'h0000},
        {4'd3, 2'd1, 5'd4,  16'h0006, 16'h0000},
        {4'd3, 2'd0, 5'd0,  16'd4,    16'h0000},
        {4'd8, 2'd1, 5'd16, 16'h0000, 16'h0000},
        {4'd8, 2'd2, 5'd20, 16'h0000, 16'hFFFF},  // R8 high half
        {4'd8, 2'd2, 5'd16, 16'h0000, 16'hFFFB},  // R8 low half
        {4'd8, 2'd1, 5'd20, 16'h1234, 16'h0000},  // R8 high write ignored
        {4'd8, 2'd2, 5'd20, 16'h0000, 16'hFFFF},
        {4'd7, 2'd1, 5'd8,  16'h0005, 16'h0000},  // R7 write while running
        {4'd7, 2'd2, 5'd0,  16'h0000, 16'h0000},
        {4'd2, 2'd2, 5'd8,  16'h0000, 16'h0005},
        {4'd2, 2'd2, 5'd12, 16'h0000, 16'hFFFF},
        {4'd7, 2'd1, 5'd16, 16'h0000, 16'h0000},
        {4'd7, 2'd2, 5'd16, 16'h0000, 16'h0005},
        {4'd7, 2'd2, 5'd20, 16'h0000, 16'hFFFF},
        {4'd3, 2'd1, 5'd8,  16'h0000, 16'h0000},  // period = 0
        {4'd3, 2'd1, 5'd12, 16'h0000, 16'h0000},
        {4'd3, 2'd1, 5'd4,  16'h0006, 16'h0000},
        {4'd3, 2'd2, 5'd0,  16'h0000, 16'h0002},
        {4'd3, 2'd2, 5'd0,  16'h0000, 16'h0003},  // R3 one-cycle period
        {4'd6, 2'd1, 5'd4,  16'h0008, 16'h0000},
        {4'd2, 2'd2, 5'd24, 16'h0000, 16'h0000}   // R2 unused index
    };

    // Record one comparison.
    task automatic check(input int req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL R%0d: actual %h expected %h", req, act, exp);
        end
    endtask

    // One write, consuming one rising edge.
    task automatic do_wr(input logic [4:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk);
        #1 bus_wr = 1'b0;
    endtask

    // One read compared before the next rising edge.
    task automatic do_rd(input int req, input logic [4:0] a, input logic [15:0] e);
        @(negedge clk);
        bus_addr = a; bus_wr = 1'b0;
        #1 check(req, bus_rdata, e);
        @(posedge clk);
    endtask

    // Sample irq at the falling edge.
    task automatic chk_irq(input int req, input logic e);
        @(negedge clk);
        #1 check(req, {15'd0, irq}, {15'd0, e});
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        chk_irq(1, 1'b0);  // R1 irq low after reset

        for (int i = 0; i < NV; i++) begin
            case (VEC[i][38:37])
                2'd0: repeat (int'(VEC[i][31:16])) @(posedge clk);
                2'd1: do_wr(VEC[i][36:32], VEC[i][31:16]);
                default: do_rd(int'(VEC[i][42:39]), VEC[i][36:32], VEC[i][15:0]);
            endcase
        end

        // R10: flag set and stopped, enable off, then on, then off.
        chk_irq(10, 1'b0);
        do_wr(5'd4, 16'h0001);
        chk_irq(10, 1'b1);
        do_wr(5'd4, 16'h0000);
        chk_irq(10, 1'b0);
        do_wr(5'd4, 16'h0001);
        do_wr(5'd0, 16'h0000);
        chk_irq(9, 1'b0);  // R9 clear drops irq

        // R9: a clear on the same edge as a timeout leaves the flag set.
        do_wr(5'd8, 16'h0001);
        do_wr(5'd12, 16'h0000);
        do_wr(5'd4, 16'h0006);
        repeat (1) @(posedge clk);
        do_wr(5'd0, 16'h0000);
        do_rd(9, 5'd0, 16'h0003);
        do_wr(5'd4, 16'h0008);

        // R1: reset while running.
        do_wr(5'd8, 16'hFFFF);
        do_wr(5'd4, 16'h0007);
        @(negedge clk) rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        do_rd(1, 5'd0, 16'h0000);
        do_rd(1, 5'd4, 16'h0000);
        do_rd(1, 5'd8, 16'hFFFF);
        do_rd(1, 5'd12, 16'hFFFF);
        chk_irq(1, 1'b0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule